// File: doc/BRIEF.md
# Halfword NOP-Skipping Instruction Sequencer

This block owns the program counter and the fetch sequencing of a CPU whose 32-bit memory words carry either one fullword instruction or two 16-bit halfword instructions. Each cycle a fetched word may arrive. The sequencer picks the halfword the PC points at, presents it left-justified in the instruction register, and decides how far the PC moves. It keeps halfword no-operation instructions (encoding 0x0002) from using an execution slot. A NOP in the right half is squashed without issue. A left-half halfword instruction whose partner is a NOP moves the PC straight to the next word.

The block also tracks the one-instruction window that follows a context load, an interrupt entry or an interrupt-deactivate operation. During that window the instruction that issues is flagged as not interruptible. The drop feature can be turned off at run time through an enable pin. Decode and execution sit outside the block: decode supplies the halfword-format flag with each fetch, and execution consumes the issue strobe.

Top module: `hw_fetch_seq`

## Requirements
- R1: After reset the PC equals the RESET_PC parameter, `exec_stb` and `drop_pend` are 0, and the first instruction issued after reset has `int_test_ok` = 0.
- R2: When PC bit 1 is 0 the instruction register receives the fetched word unchanged. When PC bit 1 is 1 it receives `{word[15:0], 16'h0000}`. `opcode` is instruction register bits 31:26.
- R3: With `nop_en` = 1 and PC bit 1 = 1, a fetched word whose low half is 0x0002 is not issued (`exec_stb` stays 0) and the PC advances by 2 in the same cycle.
- R4: With `nop_en` = 1 and PC bit 1 = 0, a halfword-format instruction whose fetched word has low half 0x0002 issues, the PC advances by 4, and `drop_pend` is 1 for the following cycle.
- R5: With `nop_en` = 0 no NOP is squashed or dropped: a right-half 0x0002 issues as an ordinary instruction, a left halfword advances the PC by 2, and `drop_pend` is forced to 0 in the cycle after `nop_en` is sampled low.
- R6: An issued fullword instruction moves the PC to the word-aligned address plus 4. A left halfword without a NOP partner advances the PC by 2, and so does a right halfword.
- R7: `ctx_load` loads the PC from `ctx_pc`, discards any fetch offered in the same cycle, clears `drop_pend`, and makes the next issued instruction carry `int_test_ok` = 0.
- R8: The interrupt-test skip covers exactly one issued instruction. It persists across squashed NOPs. The issue after it carries `int_test_ok` = 1. `int_hold` sets the skip without changing the PC.
- R9: A fetch with `fetch_fault` = 1 issues nothing, leaves the PC unchanged and clears `drop_pend`.
- R10: `drop_pend` returns to 0 on the next accepted fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nop_en | input | 1 | Enables squashing and dropping of halfword NOPs |
| fetch_valid | input | 1 | A fetched word is offered this cycle |
| fetch_word | input | 32 | Fetched memory word at the word address of the PC |
| fetch_fault | input | 1 | The offered fetch faulted |
| hw_fmt | input | 1 | Decode: the instruction at the PC is halfword format |
| ctx_load | input | 1 | New context (context load or interrupt entry) |
| ctx_pc | input | ADDR_W | PC loaded with `ctx_load` |
| int_hold | input | 1 | Interrupt-deactivate executed: suppress the next interrupt test |
| ir | output | 32 | Instruction register, left-justified |
| opcode | output | 6 | Classification opcode, instruction register bits 31:26 |
| pc | output | ADDR_W | Address of the next instruction to fetch |
| exec_stb | output | 1 | One-cycle pulse: the instruction register holds a new instruction |
| int_test_ok | output | 1 | With `exec_stb`: interrupts may be sampled after this instruction |
| drop_pend | output | 1 | The last issue dropped its right-half NOP partner |

## Verification
The hardest state to reach is a pending interrupt-test skip that must outlive a squashed right-half NOP and only then be consumed by the next real issue. To get there the stimulus loads a context at a right-half address, offers a word whose low half is the NOP, and then checks `int_test_ok` on the two issues that follow. A second hard case is a fault that lands while a drop is still flagged. The bench first issues a left halfword with a NOP partner, and then faults the very next fetch.

// File: rtl/hw_fetch_seq_pkg.sv
package hw_fetch_seq_pkg;

    localparam logic [15:0] HW_NOP = 16'h0002;
    localparam int unsigned OPC_W = 6;

    typedef enum logic {
        STEP_HALF = 1'b0,
        STEP_WORD = 1'b1
    } step_kind_e;

endpackage

// File: rtl/hw_fetch_align.sv
module hw_fetch_align
    import hw_fetch_seq_pkg::*;
(
    input  logic [31:0] word_in,
    input  logic        sel_right,
    output logic [31:0] ir_view,
    output logic        right_is_nop,
    output logic        partner_is_nop
);
    always_comb begin
        ir_view        = sel_right ? {word_in[15:0], 16'h0000} : word_in;
        right_is_nop   = sel_right && (word_in[15:0] == HW_NOP);
        partner_is_nop = !sel_right && (word_in[15:0] == HW_NOP);
    end
endmodule

// File: rtl/hw_fetch_step.sv
module hw_fetch_step
    import hw_fetch_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter step_kind_e  KIND   = STEP_HALF
) (
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc_out
);
    localparam logic [ADDR_W-1:0] HALF_INC = ADDR_W'(2);
    localparam logic [ADDR_W-3:0] WORD_INC = (ADDR_W-2)'(1);

    generate
        if (KIND == STEP_WORD) begin : g_word
            always_comb pc_out = {pc_in[ADDR_W-1:2] + WORD_INC, 2'b00};
        end else begin : g_half
            always_comb pc_out = pc_in + HALF_INC;
        end
    endgenerate
endmodule

// File: rtl/hw_fetch_seq.sv
module hw_fetch_seq
    import hw_fetch_seq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(256)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nop_en,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_word,
    input  logic              fetch_fault,
    input  logic              hw_fmt,
    input  logic              ctx_load,
    input  logic [ADDR_W-1:0] ctx_pc,
    input  logic              int_hold,
    output logic [31:0]       ir,
    output logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] pc,
    output logic              exec_stb,
    output logic              int_test_ok,
    output logic              drop_pend
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [31:0]       ir;
        logic [OPC_W-1:0]  opc;
        logic              exec;
        logic              int_ok;
        logic              skip;
        logic              drop;
    } seq_state_t;

    seq_state_t state_q, state_d;

    logic [31:0]       ir_view;
    logic              right_nop;
    logic              partner_nop;
    logic [ADDR_W-1:0] pc_half;
    logic [ADDR_W-1:0] pc_word;

    hw_fetch_align u_align (
        .word_in        (fetch_word),
        .sel_right      (state_q.pc[1]),
        .ir_view        (ir_view),
        .right_is_nop   (right_nop),
        .partner_is_nop (partner_nop)
    );

    hw_fetch_step #(.ADDR_W(ADDR_W), .KIND(STEP_HALF)) u_step_half (
        .pc_in  (state_q.pc),
        .pc_out (pc_half)
    );

    hw_fetch_step #(.ADDR_W(ADDR_W), .KIND(STEP_WORD)) u_step_word (
        .pc_in  (state_q.pc),
        .pc_out (pc_word)
    );

    always_comb begin
        state_d        = state_q;
        state_d.exec   = 1'b0;
        state_d.int_ok = 1'b0;
        if (!nop_en) begin
            state_d.drop = 1'b0;
        end
        if (ctx_load) begin
            state_d.pc   = ctx_pc;
            state_d.skip = 1'b1;
            state_d.drop = 1'b0;
        end else begin
            if (fetch_valid) begin
                state_d.drop = 1'b0;
                if (fetch_fault) begin
                    state_d.pc = state_q.pc;
                end else if (nop_en && right_nop) begin
                    state_d.pc = pc_half;
                end else begin
                    state_d.ir     = ir_view;
                    state_d.opc    = ir_view[31:32-OPC_W];
                    state_d.exec   = 1'b1;
                    state_d.int_ok = !state_q.skip;
                    state_d.skip   = 1'b0;
                    if (state_q.pc[1]) begin
                        state_d.pc = pc_half;
                    end else if (!hw_fmt) begin
                        state_d.pc = pc_word;
                    end else if (nop_en && partner_nop) begin
                        state_d.pc   = pc_word;
                        state_d.drop = 1'b1;
                    end else begin
                        state_d.pc = pc_half;
                    end
                end
            end
            if (int_hold) begin
                state_d.skip = 1'b1;
                state_d.drop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc     <= RESET_PC;
            state_q.ir     <= '0;
            state_q.opc    <= '0;
            state_q.exec   <= 1'b0;
            state_q.int_ok <= 1'b0;
            state_q.skip   <= 1'b1;
            state_q.drop   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ir          = state_q.ir;
    assign opcode      = state_q.opc;
    assign pc          = state_q.pc;
    assign exec_stb    = state_q.exec;
    assign int_test_ok = state_q.int_ok;
    assign drop_pend   = state_q.drop;
endmodule

// File: rtl/hw_fetch_seq_chk.sv
module hw_fetch_seq_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nop_en,
    input logic              fetch_valid,
    input logic [31:0]       fetch_word,
    input logic              fetch_fault,
    input logic              ctx_load,
    input logic [ADDR_W-1:0] ctx_pc,
    input logic [ADDR_W-1:0] pc,
    input logic              exec_stb,
    input logic              int_test_ok,
    input logic              drop_pend
);
    localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);

    AST_RIGHT_NOP_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_fault && !ctx_load && nop_en && pc[1] &&
         fetch_word[15:0] == 16'h0002) |=> !exec_stb) else $error("right NOP issued"); // R3

    AST_DROP_ADVANCES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drop_pend) |-> (exec_stb && pc == $past(pc) + STEP4)) else $error("drop step"); // R4

    AST_DISABLED_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !nop_en |=> !drop_pend) else $error("drop while disabled"); // R5

    AST_CTX_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> (pc == $past(ctx_pc) && !exec_stb && !drop_pend)) else $error("ctx load"); // R7

    AST_INT_OK_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        int_test_ok |-> exec_stb) else $error("int_test_ok without issue"); // R8

    AST_FAULT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_fault && !ctx_load) |=> ($stable(pc) && !exec_stb && !drop_pend))
        else $error("fault handling"); // R9

    AST_DROP_CLEARS_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pend && fetch_valid && !ctx_load) |=> !drop_pend || exec_stb) else $error("drop stuck"); // R10
endmodule

bind hw_fetch_seq hw_fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nop_en      (nop_en),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .fetch_fault (fetch_fault),
    .ctx_load    (ctx_load),
    .ctx_pc      (ctx_pc),
    .pc          (pc),
    .exec_stb    (exec_stb),
    .int_test_ok (int_test_ok),
    .drop_pend   (drop_pend)
);

// File: tb/hw_fetch_seq_tb.sv
module hw_fetch_seq_tb_top;
    localparam int unsigned ADDR_W = 24;
    localparam logic [ADDR_W-1:0] RST_PC = 24'h000100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              nop_en = 1'b1;
    logic              fetch_valid = 1'b0;
    logic [31:0]       fetch_word = '0;
    logic              fetch_fault = 1'b0;
    logic              hw_fmt = 1'b0;
    logic              ctx_load = 1'b0;
    logic [ADDR_W-1:0] ctx_pc = '0;
    logic              int_hold = 1'b0;
    logic [31:0]       ir;
    logic [5:0]        opcode;
    logic [ADDR_W-1:0] pc;
    logic              exec_stb;
    logic              int_test_ok;
    logic              drop_pend;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hw_fetch_seq #(.ADDR_W(ADDR_W), .RESET_PC(RST_PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .nop_en(nop_en), .fetch_valid(fetch_valid),
        .fetch_word(fetch_word), .fetch_fault(fetch_fault), .hw_fmt(hw_fmt),
        .ctx_load(ctx_load), .ctx_pc(ctx_pc), .int_hold(int_hold),
        .ir(ir), .opcode(opcode), .pc(pc), .exec_stb(exec_stb),
        .int_test_ok(int_test_ok), .drop_pend(drop_pend)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0; fetch_fault = 1'b0; hw_fmt = 1'b0;
        ctx_load = 1'b0; int_hold = 1'b0;
    endtask

    // drive one cycle of stimulus, then sample just after the edge
    task automatic cyc(input logic v, input logic [31:0] w, input logic hw, input logic flt);
        @(negedge clk);
        idle_inputs();
        fetch_valid = v; fetch_word = w; hw_fmt = hw; fetch_fault = flt;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic load_ctx(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        idle_inputs();
        ctx_load = 1'b1; ctx_pc = a;
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 pc", 32'(pc), 32'(RST_PC));
        chk("R1 exec", 32'(exec_stb), 0);
        chk("R1 drop", 32'(drop_pend), 0);
    endtask

    task automatic t_left_right();
        cyc(1, 32'h1234_5678, 1, 0);
        chk("R2 left ir", ir, 32'h1234_5678);
        chk("R2 opcode", 32'(opcode), 32'(6'(32'h1234_5678 >> 26)));
        chk("R1 first issue int_ok", 32'(int_test_ok), 0);
        chk("R6 left hw pc", 32'(pc), 32'h102);
        cyc(1, 32'h1234_5678, 1, 0);
        chk("R2 right ir", ir, 32'h5678_0000);
        chk("R8 second issue int_ok", 32'(int_test_ok), 1);
        chk("R6 right hw pc", 32'(pc), 32'h104);
    endtask

    task automatic t_fullword();
        cyc(1, 32'hA000_0000, 0, 0);
        chk("R6 fullword exec", 32'(exec_stb), 1);
        chk("R6 fullword pc", 32'(pc), 32'h108);
    endtask

    task automatic t_right_nop_skip();
        load_ctx(24'h000202);
        chk("R7 ctx pc", 32'(pc), 32'h202);
        cyc(1, 32'hC001_0002, 1, 0);
        chk("R3 squash exec", 32'(exec_stb), 0);
        chk("R3 squash pc", 32'(pc), 32'h204);
        cyc(1, 32'h8000_0000, 0, 0);
        chk("R8 skip survives squash", 32'(int_test_ok), 0);
        chk("R7 issue after ctx", 32'(exec_stb), 1);
        cyc(1, 32'h8000_0000, 0, 0);
        chk("R8 skip one instr only", 32'(int_test_ok), 1);
    endtask

    task automatic t_drop();
        load_ctx(24'h000400);
        cyc(1, 32'h4800_0002, 1, 0);
        chk("R4 drop exec", 32'(exec_stb), 1);
        chk("R4 drop ir", ir, 32'h4800_0002);
        chk("R4 drop pc", 32'(pc), 32'h404);
        chk("R4 drop_pend", 32'(drop_pend), 1);
        cyc(1, 32'h9000_0000, 0, 0);
        chk("R10 drop clears", 32'(drop_pend), 0);
        chk("R6 pc after", 32'(pc), 32'h408);
    endtask

    task automatic t_disabled();
        nop_en = 1'b0;
        load_ctx(24'h000300);
        cyc(1, 32'h4800_0002, 1, 0);
        chk("R5 no drop pc", 32'(pc), 32'h302);
        chk("R5 no drop flag", 32'(drop_pend), 0);
        cyc(1, 32'h4800_0002, 1, 0);
        chk("R5 right nop issues", 32'(exec_stb), 1);
        chk("R5 right nop ir", ir, 32'h0002_0000);
        chk("R5 pc", 32'(pc), 32'h304);
        nop_en = 1'b1;
        cyc(1, 32'h4800_0002, 1, 0);
        chk("R4 drop set again", 32'(drop_pend), 1);
        @(negedge clk); nop_en = 1'b0;
        @(posedge clk); #1;
        chk("R5 forced clear", 32'(drop_pend), 0);
        nop_en = 1'b1;
    endtask

    task automatic t_fault();
        load_ctx(24'h000500);
        cyc(1, 32'h4800_0002, 1, 0);
        chk("R4 pre-fault drop", 32'(drop_pend), 1);
        cyc(1, 32'h1111_1111, 0, 1);
        chk("R9 fault no exec", 32'(exec_stb), 0);
        chk("R9 fault pc held", 32'(pc), 32'h504);
        chk("R9 fault drop clear", 32'(drop_pend), 0);
    endtask

    task automatic t_hold_and_override();
        cyc(1, 32'h2000_0000, 0, 0);
        @(negedge clk); idle_inputs(); int_hold = 1'b1;
        @(posedge clk); #1; idle_inputs();
        chk("R8 hold pc", 32'(pc), 32'h508);
        cyc(1, 32'h2000_0000, 0, 0);
        chk("R8 hold int_ok", 32'(int_test_ok), 0);
        cyc(1, 32'h2000_0000, 0, 0);
        chk("R8 after hold", 32'(int_test_ok), 1);
        @(negedge clk); idle_inputs();
        ctx_load = 1'b1; ctx_pc = 24'h000600;
        fetch_valid = 1'b1; fetch_word = 32'h3000_0000;
        @(posedge clk); #1; idle_inputs();
        chk("R7 override exec", 32'(exec_stb), 0);
        chk("R7 override pc", 32'(pc), 32'h600);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_left_right();
        t_fullword();
        t_right_nop_skip();
        t_drop();
        t_disabled();
        t_fault();
        t_hold_and_override();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule